// File: doc/BRIEF.md
# Error-Gated Transaction Receive Buffer

This block sits between a byte-level receiver and a translation engine. Each incoming transaction is a command byte, then a fixed number of header bytes, then any write data. Bytes arrive one per accepted cycle. Each one is written into a staging buffer. On the byte marked as the end of the transaction, the block samples two inputs: a CRC-error flag and a class tag. The class tag says whether the transaction is posted or non-posted.

A transaction that fails is removed whole in one step, by moving the staging write pointer back to where the transaction began. A transaction that passes is copied into the posted queue or the non-posted queue, one byte per cycle. Input is held off for the length of that copy. A transaction longer than one command byte, the header and the maximum payload cannot be held whole, so it is discarded.

Each queue is a plain byte FIFO with a pop interface. Each queue also drives a registered flag that says whether it has room for a complete worst-case transaction of its class. The posted threshold counts command, header and maximum payload. The non-posted threshold counts command and header only.

Top module: `txn_rx_gate`

## Requirements
- R1: After reset, `in_ready` is 1, both queues report empty, and both free flags are 1.
- R2: The bytes of a committed transaction leave its queue in the order they arrived, and successive transactions leave in arrival order.
- R3: If `in_crc_err` is 1 on the accepted end byte, no byte of that transaction ever appears in either queue. `in_ready` is 1 again in the very next cycle.
- R4: A clean transaction goes to the posted queue when `in_posted` is 1 on its end byte, and to the non-posted queue when it is 0. It never goes to both.
- R5: No byte of a transaction enters a queue before its end byte has been accepted.
- R6: After the end byte of a clean N-byte transaction is accepted, and while the target queue has room, `in_ready` stays 0 for exactly N cycles.
- R7: `pq_free` is 1 exactly when the free entries of the posted queue are at least 1 + HDR_BYTES + MAX_PAYLOAD (13 with the default parameters). It changes only on a cycle with a posted push or pop.
- R8: `np_free` is 1 exactly when the free entries of the non-posted queue are at least 1 + HDR_BYTES (5 with the default parameters). It changes only on a cycle with a non-posted push or pop.
- R9: If the target queue fills during a copy, the copy pauses with `in_ready` held at 0. It resumes after pops, and no byte is lost.
- R10: A transaction of more than 1 + HDR_BYTES + MAX_PAYLOAD bytes is accepted in full and then discarded entirely, even without a CRC error.
- R11: A pop request on an empty queue has no effect on its contents or its order.
- R12: A queue holds several committed transactions at once, up to its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a transaction |
| in_crc_err | input | 1 | CRC verdict, sampled with the final byte (1 = bad) |
| in_posted | input | 1 | Class, sampled with the final byte (1 = posted) |
| in_ready | output | 1 | Block can take a byte this cycle |
| pq_pop | input | 1 | Remove the head byte of the posted queue |
| pq_data | output | 8 | Head byte of the posted queue |
| pq_empty | output | 1 | Posted queue holds no bytes |
| pq_free | output | 1 | Posted queue can take a worst-case transaction |
| np_pop | input | 1 | Remove the head byte of the non-posted queue |
| np_data | output | 8 | Head byte of the non-posted queue |
| np_empty | output | 1 | Non-posted queue holds no bytes |
| np_free | output | 1 | Non-posted queue can take a worst-case transaction |

## Verification
The bench probes the free thresholds at the exact boundary: 5 and then 4 free entries on the non-posted queue, and 13 and then 12 on the posted queue. An off-by-one compare would raise or drop a flag one byte early. Transactions with an error, and transactions one byte over the limit, are both sent. A rollback that restored the wrong pointer would leak stale bytes or lose queued ones. A design that made the drop take drain cycles would hold `in_ready` low where the bench expects it high. A copy into a queue that fills midway would show either a lost byte or reordering when the bench drains it. Pops on an empty queue test that the pointers do not move when they should not.

// File: rtl/txn_rx_pkg.sv
package txn_rx_pkg;

    typedef enum logic [0:0] {
        ST_ACCEPT = 1'b0,
        ST_MOVE   = 1'b1
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
        logic        to_posted;
        logic        ovf;
    } gate_regs_t;

    localparam gate_regs_t GATE_RESET = '{state: ST_ACCEPT, to_posted: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/txn_byte_queue.sv
module txn_byte_queue #(
    parameter int DEPTH = 16,
    parameter int NEED  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] wdata,
    input  logic       pop,
    output logic [7:0] rdata,
    output logic       empty,
    output logic       full,
    output logic       free
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          free;
    } q_regs_t;

    q_regs_t    r_q, r_d;
    logic [7:0] mem_q [DEPTH];
    logic       do_push;
    logic       do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d     = r_q;
        do_push = push && (r_q.cnt != CW'(DEPTH));
        do_pop  = pop && (r_q.cnt != '0);
        if (do_push) r_d.wp = step(r_q.wp);
        if (do_pop)  r_d.rp = step(r_q.rp);
        if (do_push && !do_pop)      r_d.cnt = r_q.cnt + CW'(1);
        else if (do_pop && !do_push) r_d.cnt = r_q.cnt - CW'(1);
        r_d.free = (DEPTH - int'(r_d.cnt)) >= NEED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{wp: '0, rp: '0, cnt: '0, free: (DEPTH >= NEED)};
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[r_q.wp] <= wdata;
    end

    assign rdata = mem_q[r_q.rp];
    assign empty = (r_q.cnt == '0);
    assign full  = (r_q.cnt == CW'(DEPTH));
    assign free  = r_q.free;

endmodule

// File: rtl/txn_stage_buf.sv
module txn_stage_buf #(
    parameter int DEPTH = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] wdata,
    input  logic       mark,
    input  logic       drop,
    input  logic       pop,
    output logic [7:0] rdata,
    output logic       empty,
    output logic       full,
    output logic       one_left
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW-1:0] mk;
        logic [CW-1:0] cnt;
        logic [CW-1:0] pend;
    } s_regs_t;

    s_regs_t    r_q, r_d;
    logic [7:0] mem_q [DEPTH];
    logic       do_push;
    logic       do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d     = r_q;
        do_push = push && !drop && (r_q.cnt != CW'(DEPTH));
        do_pop  = pop && (r_q.cnt != '0);
        if (drop) begin
            r_d.wp   = r_q.mk;
            r_d.cnt  = r_q.cnt - r_q.pend;
            r_d.pend = '0;
        end else begin
            if (do_push) begin
                r_d.wp   = step(r_q.wp);
                r_d.pend = r_q.pend + CW'(1);
            end
            if (do_push && !do_pop)      r_d.cnt = r_q.cnt + CW'(1);
            else if (do_pop && !do_push) r_d.cnt = r_q.cnt - CW'(1);
            if (mark) begin
                r_d.mk   = r_d.wp;
                r_d.pend = '0;
            end
        end
        if (do_pop) r_d.rp = step(r_q.rp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[r_q.wp] <= wdata;
    end

    assign rdata    = mem_q[r_q.rp];
    assign empty    = (r_q.cnt == '0);
    assign full     = (r_q.cnt == CW'(DEPTH));
    assign one_left = (r_q.cnt == CW'(1));

endmodule

// File: rtl/txn_rx_gate.sv
module txn_rx_gate
    import txn_rx_pkg::*;
#(
    parameter int HDR_BYTES   = 4,
    parameter int MAX_PAYLOAD = 8,
    parameter int PQ_DEPTH    = 32,
    parameter int NP_DEPTH    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_crc_err,
    input  logic       in_posted,
    output logic       in_ready,
    input  logic       pq_pop,
    output logic [7:0] pq_data,
    output logic       pq_empty,
    output logic       pq_free,
    input  logic       np_pop,
    output logic [7:0] np_data,
    output logic       np_empty,
    output logic       np_free
);
    localparam int CMD_BYTES   = 1;
    localparam int NP_NEED     = CMD_BYTES + HDR_BYTES;
    localparam int PQ_NEED     = NP_NEED + MAX_PAYLOAD;
    localparam int STAGE_DEPTH = PQ_NEED;

    gate_regs_t r_q, r_d;

    logic       accept_fire;
    logic       is_drop;
    logic       go_move;
    logic       move_byte;
    logic       tgt_full;
    logic       stg_push;
    logic       stg_empty;
    logic       stg_full;
    logic       stg_one_left;
    logic [7:0] stg_rdata;
    logic       pq_push;
    logic       np_push;
    logic       pq_full;
    logic       np_full;

    always_comb begin
        r_d         = r_q;
        accept_fire = in_valid && (r_q.state == ST_ACCEPT);
        is_drop     = accept_fire && in_last && (in_crc_err || r_q.ovf || stg_full);
        stg_push    = accept_fire && !stg_full && !is_drop;
        go_move     = accept_fire && in_last && !is_drop;
        tgt_full    = r_q.to_posted ? pq_full : np_full;
        move_byte   = (r_q.state == ST_MOVE) && !stg_empty && !tgt_full;
        pq_push     = move_byte && r_q.to_posted;
        np_push     = move_byte && !r_q.to_posted;

        if (accept_fire) r_d.ovf = in_last ? 1'b0 : (r_q.ovf || stg_full);
        if (go_move) begin
            r_d.state     = ST_MOVE;
            r_d.to_posted = in_posted;
        end
        if (move_byte && stg_one_left) r_d.state = ST_ACCEPT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= GATE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.state == ST_ACCEPT);

    txn_stage_buf #(.DEPTH(STAGE_DEPTH)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stg_push),
        .wdata    (in_data),
        .mark     (go_move),
        .drop     (is_drop),
        .pop      (move_byte),
        .rdata    (stg_rdata),
        .empty    (stg_empty),
        .full     (stg_full),
        .one_left (stg_one_left)
    );

    txn_byte_queue #(.DEPTH(PQ_DEPTH), .NEED(PQ_NEED)) u_pq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (pq_push),
        .wdata (stg_rdata),
        .pop   (pq_pop),
        .rdata (pq_data),
        .empty (pq_empty),
        .full  (pq_full),
        .free  (pq_free)
    );

    txn_byte_queue #(.DEPTH(NP_DEPTH), .NEED(NP_NEED)) u_np (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (np_push),
        .wdata (stg_rdata),
        .pop   (np_pop),
        .rdata (np_data),
        .empty (np_empty),
        .full  (np_full),
        .free  (np_free)
    );

endmodule

// File: rtl/txn_rx_gate_chk.sv
module txn_rx_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_last,
    input logic in_crc_err,
    input logic go_move,
    input logic pq_push,
    input logic np_push,
    input logic pq_pop,
    input logic np_pop,
    input logic pq_empty,
    input logic np_empty,
    input logic pq_free,
    input logic np_free
);
    AST_DROP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last && in_crc_err |=> in_ready); // R3

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(pq_push && np_push)); // R4

    AST_NO_PUSH_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !(pq_push || np_push)); // R5

    AST_COMMIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        go_move |=> !in_ready); // R6

    AST_PQ_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pq_push && !pq_pop |=> $stable(pq_free)); // R7

    AST_NP_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !np_push && !np_pop |=> $stable(np_free)); // R8

    AST_PQ_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        pq_empty && !pq_push |=> pq_empty); // R11

    AST_NP_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        np_empty && !np_push |=> np_empty); // R11

endmodule

bind txn_rx_gate txn_rx_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .in_crc_err (in_crc_err),
    .go_move    (go_move),
    .pq_push    (pq_push),
    .np_push    (np_push),
    .pq_pop     (pq_pop),
    .np_pop     (np_pop),
    .pq_empty   (pq_empty),
    .np_empty   (np_empty),
    .pq_free    (pq_free),
    .np_free    (np_free)
);

// File: tb/txn_rx_gate_bench.sv
module txn_rx_gate_bench;
    localparam int MAX_LEN = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_crc_err = 1'b0;
    logic       in_posted = 1'b0;
    logic       in_ready;
    logic       pq_pop = 1'b0;
    logic [7:0] pq_data;
    logic       pq_empty;
    logic       pq_free;
    logic       np_pop = 1'b0;
    logic [7:0] np_data;
    logic       np_empty;
    logic       np_free;

    int n_checks = 0;
    int n_fail   = 0;
    byte unsigned mq_pq[$];
    byte unsigned mq_np[$];

    always #2 clk = ~clk;

    txn_rx_gate u_txn_rx_gate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_crc_err(in_crc_err), .in_posted(in_posted),
        .in_ready(in_ready), .pq_pop(pq_pop), .pq_data(pq_data),
        .pq_empty(pq_empty), .pq_free(pq_free), .np_pop(np_pop),
        .np_data(np_data), .np_empty(np_empty), .np_free(np_free)
    );

    // vector: {len[4:0], posted, crc_err, seed[7:0]}
    localparam int NVEC = 8;
    localparam logic [14:0] VEC [NVEC] = '{
        {5'd5,  1'b1, 1'b0, 8'h10},
        {5'd5,  1'b0, 1'b0, 8'h20},
        {5'd3,  1'b1, 1'b1, 8'h30},
        {5'd13, 1'b1, 1'b0, 8'h40},
        {5'd1,  1'b0, 1'b0, 8'h50},
        {5'd7,  1'b0, 1'b1, 8'h60},
        {5'd2,  1'b1, 1'b0, 8'h70},
        {5'd9,  1'b0, 1'b0, 8'h80}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the last byte is taken.
    task automatic send_txn(input int len, input bit posted, input bit err,
                            input byte unsigned seed, input bit chk_hold);
        for (int i = 0; i < len; i++) begin
            in_valid   = 1'b1;
            in_data    = seed + 8'(i);
            in_last    = (i == len - 1);
            in_crc_err = err;
            in_posted  = posted;
            while (!in_ready) @(negedge clk);
            if (chk_hold && i == len - 1)
                check(pq_empty && np_empty, "R5 queues empty before end byte",
                      int'({pq_empty, np_empty}), 3);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (!err && len <= MAX_LEN) begin
            for (int i = 0; i < len; i++) begin
                if (posted) mq_pq.push_back(seed + 8'(i));
                else        mq_np.push_back(seed + 8'(i));
            end
        end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!in_ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic drain(input bit posted);
        int sz;
        sz = posted ? mq_pq.size() : mq_np.size();
        for (int i = 0; i < sz; i++) begin
            byte unsigned e;
            if (posted) begin
                e = mq_pq.pop_front();
                check(!pq_empty && pq_data == e, "R2 posted byte order", int'(pq_data), int'(e));
                pq_pop = 1'b1;
            end else begin
                e = mq_np.pop_front();
                check(!np_empty && np_data == e, "R2 non-posted byte order", int'(np_data), int'(e));
                np_pop = 1'b1;
            end
            @(negedge clk);
        end
        pq_pop = 1'b0;
        np_pop = 1'b0;
    endtask

    task automatic check_all_empty(input string req);
        check(pq_empty, req, int'(pq_empty), 1);
        check(np_empty, req, int'(np_empty), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int busy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
        check(pq_empty && np_empty, "R1 queues empty after reset", int'({pq_empty, np_empty}), 3);
        check(pq_free && np_free, "R1 free flags after reset", int'({pq_free, np_free}), 3);

        // Vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            int  len;
            bit  posted, err;
            len    = int'(VEC[v][14:10]);
            posted = VEC[v][9];
            err    = VEC[v][8];
            send_txn(len, posted, err, VEC[v][7:0], len > 1);
            count_busy(busy);
            if (err) check(busy == 0, "R3 dropped txn costs no busy cycles", busy, 0);
            else     check(busy == len, "R6 busy cycles equal txn length", busy, len);
            if (err) begin
                check_all_empty("R3 dropped txn absent from queues");
            end else begin
                check(posted ? !pq_empty && np_empty : pq_empty && !np_empty,
                      "R4 routed to class queue", int'({pq_empty, np_empty}),
                      posted ? 1 : 2);
                drain(posted);
            end
            check_all_empty("R2 queue empty after drain");
        end

        // R10 over-length transaction is discarded
        send_txn(MAX_LEN + 1, 1'b1, 1'b0, 8'h90, 1'b0);
        count_busy(busy);
        check(busy == 0, "R10 over-length dropped without copy", busy, 0);
        check_all_empty("R10 over-length absent");
        send_txn(3, 1'b1, 1'b0, 8'hA0, 1'b0);
        count_busy(busy);
        drain(1'b1);
        check_all_empty("R10 stage clean after over-length drop");

        // R11 pops on empty queues are ignored
        pq_pop = 1'b1;
        np_pop = 1'b1;
        repeat (3) @(negedge clk);
        pq_pop = 1'b0;
        np_pop = 1'b0;
        send_txn(2, 1'b0, 1'b0, 8'hB0, 1'b0);
        count_busy(busy);
        check(!np_empty && np_data == 8'hB0, "R11 head after empty pops", int'(np_data), 'hB0);
        drain(1'b0);
        check_all_empty("R11 exact length after empty pops");

        // R7 posted threshold (depth 32, need 13), R12 several txns held
        send_txn(13, 1'b1, 1'b0, 8'hC0, 1'b0);
        count_busy(busy);
        check(pq_free, "R7 19 free entries keeps pq_free", int'(pq_free), 1);
        send_txn(6, 1'b1, 1'b0, 8'hD0, 1'b0);
        count_busy(busy);
        check(pq_free, "R7 13 free entries keeps pq_free", int'(pq_free), 1);
        send_txn(1, 1'b1, 1'b0, 8'hE0, 1'b0);
        count_busy(busy);
        check(!pq_free, "R7 12 free entries clears pq_free", int'(pq_free), 0);
        check(np_free, "R7 np_free unaffected by posted traffic", int'(np_free), 1);
        drain(1'b1);
        check(pq_free && pq_empty, "R12 all three posted txns drained", int'({pq_free, pq_empty}), 3);

        // R8 non-posted threshold (depth 16, need 5) and R9 stall
        send_txn(5, 1'b0, 1'b0, 8'h01, 1'b0);
        count_busy(busy);
        send_txn(5, 1'b0, 1'b0, 8'h11, 1'b0);
        count_busy(busy);
        check(np_free, "R8 6 free entries keeps np_free", int'(np_free), 1);
        send_txn(1, 1'b0, 1'b0, 8'h21, 1'b0);
        count_busy(busy);
        check(np_free, "R8 5 free entries keeps np_free", int'(np_free), 1);
        send_txn(1, 1'b0, 1'b0, 8'h31, 1'b0);
        count_busy(busy);
        check(!np_free, "R8 4 free entries clears np_free", int'(np_free), 0);
        send_txn(5, 1'b0, 1'b0, 8'h41, 1'b0);
        repeat (10) @(negedge clk);
        check(!in_ready, "R9 copy stalls on full queue", int'(in_ready), 0);
        drain(1'b0);
        check(in_ready, "R9 copy completes after pops", int'(in_ready), 1);
        check_all_empty("R9 no byte lost or extra");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule